// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block sequences data transfers between a fast volatile array and its nonvolatile backup. A store copies the array into the backup in two timed phases. The first phase clears the old backup contents. The second phase writes the new data. A recall runs the transfer the other way, from the backup into the array.

Three sources can start a store: a power-fail detector (used only while automatic store is enabled), a software STORE opcode, and an external hardware request pin. A recall starts by itself after reset and when power returns, and a RECALL opcode can also start one.

While a transfer is running, the block signals busy in two ways: on an active-low output and on a status bit. It also locks out all other traffic. A written-since-last-transfer flag lets the block skip automatic and hardware stores that would change nothing. The three phase lengths are parameters, counted in clock cycles.

Top module: `nv_store_seq`

States:
- `ST_IDLE`: open for traffic.
- `ST_ERASE`: clearing the backup.
- `ST_PROGRAM`: writing the backup.
- `ST_RECALL`: copying the backup into the array.
- `ST_OFF`: powered down, locked, not busy.

Transitions:
- Reset goes to `ST_RECALL`.
- `ST_IDLE` goes to `ST_ERASE` on an accepted store.
- `ST_IDLE` goes to `ST_RECALL` on a RECALL opcode.
- `ST_IDLE` goes to `ST_OFF` on a power fail that needs no store.
- `ST_ERASE` goes to `ST_PROGRAM` when its timer expires.
- `ST_PROGRAM` goes to `ST_OFF` (power still failing) or to `ST_IDLE` when its timer expires.
- `ST_RECALL` goes to `ST_IDLE` when its timer expires.
- `ST_OFF` goes to `ST_RECALL` when power returns.

## Requirements
- R1: After reset the block runs a recall lasting RECALL_CYC cycles, with `nv_recall` high and I/O locked, and then goes idle.
- R2: Every store holds `nv_erase` high for exactly ERASE_CYC cycles, followed immediately by `nv_prog` high for exactly PROG_CYC cycles.
- R3: `hsb_n` is low and `status_rdy` is high exactly while an erase, program or recall phase runs, and at no other time.
- R4: `io_lock` is high in every state except idle. Opcodes, hardware requests and byte-write completions (`sram_wr_done`) that arrive while it is high have no effect.
- R5: The dirty flag is set by a byte-write completion accepted while idle and cleared at the end of every store and every recall. A hardware store request while the flag is clear starts nothing.
- R6: Opcode 0x3C (software store) starts a store whether or not the dirty flag is set.
- R7: Opcode 0x60 starts a recall lasting RECALL_CYC cycles, and the recall clears the dirty flag.
- R8: Opcode 0x19 disables automatic store and opcode 0x59 enables it. It is enabled after reset. Any other opcode value has no effect.
- R9: When `power_fail` rises while idle, the block stores first only if automatic store is enabled and the dirty flag is set. It then enters the off state (`io_lock` high, `hsb_n` high). When `power_fail` falls, it runs a recall.
- R10: In idle, `power_fail` takes priority over a hardware request, and a hardware request with the dirty flag set takes priority over an opcode arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode strobe, one cycle |
| op_code | input | 8 | Instruction opcode |
| sram_wr_done | input | 1 | Pulse when a volatile byte write completes |
| hw_store_req | input | 1 | External hardware store request |
| power_fail | input | 1 | Power-down detected (level) |
| hsb_n | output | 1 | Active-low busy indication |
| status_rdy | output | 1 | Busy status bit (1 = busy) |
| io_lock | output | 1 | All external access blocked |
| nv_erase | output | 1 | Backup erase phase active |
| nv_prog | output | 1 | Backup program phase active |
| nv_recall | output | 1 | Recall transfer active |

## Verification
The assertions assume the following about the inputs:
- `op_valid`, `sram_wr_done` and `hw_store_req` are synchronous to `clk`.
- `power_fail` is a level that stays high until the block has reached the off state.
- All phase parameters are at least 1.

The stimulus drives every input on the falling edge and pulses the strobes for exactly one cycle. It changes `power_fail` only when the block is idle or already off. Random actions are drawn only while the block is idle. Deliberate traffic during busy phases is injected only by the directed lock-out case.

// File: rtl/nv_store_seq_pkg.sv
package nv_store_seq_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OPC_STORE  = 8'h3C;
    localparam logic [OP_W-1:0] OPC_RECALL = 8'h60;
    localparam logic [OP_W-1:0] OPC_AE_OFF = 8'h19;
    localparam logic [OP_W-1:0] OPC_AE_ON  = 8'h59;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERASE,
        ST_PROGRAM,
        ST_RECALL,
        ST_OFF
    } seq_state_e;

    typedef struct packed {
        logic store;
        logic recall;
        logic ae_on;
        logic ae_off;
    } seq_cmd_t;

endpackage

// File: rtl/nv_cmd_decode.sv
module nv_cmd_decode
    import nv_store_seq_pkg::*;
(
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic            accept,
    output seq_cmd_t        cmd
);

    logic take;

    always_comb begin
        take       = op_valid && accept;
        cmd        = '0;
        cmd.store  = take && (op_code == OPC_STORE);
        cmd.recall = take && (op_code == OPC_RECALL);
        cmd.ae_on  = take && (op_code == OPC_AE_ON);
        cmd.ae_off = take && (op_code == OPC_AE_OFF);
    end

endmodule

// File: rtl/nv_seq_flags.sv
module nv_seq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_done,
    input  logic accept_wr,
    input  logic clr_dirty,
    input  logic ae_on,
    input  logic ae_off,
    output logic dirty,
    output logic ae
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dirty <= 1'b0;
            ae    <= 1'b1;
        end else begin
            if (clr_dirty) begin
                dirty <= 1'b0;
            end else if (wr_done && accept_wr) begin
                dirty <= 1'b1;
            end
            if (ae_on) begin
                ae <= 1'b1;
            end else if (ae_off) begin
                ae <= 1'b0;
            end
        end
    end

    AST_AE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(ae_on || ae_off) |=> $stable(ae)); // R8

    AST_DIRTY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_wr && !clr_dirty) |=> $stable(dirty)); // R4

endmodule

// File: rtl/nv_phase_timer.sv
module nv_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expired = (cnt_q == limit - CNT_W'(1));

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !expired) |=> (cnt_q != '0)); // R2

endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq
    import nv_store_seq_pkg::*;
#(
    parameter int ERASE_CYC  = 6,
    parameter int PROG_CYC   = 9,
    parameter int RECALL_CYC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic            sram_wr_done,
    input  logic            hw_store_req,
    input  logic            power_fail,
    output logic            hsb_n,
    output logic            status_rdy,
    output logic            io_lock,
    output logic            nv_erase,
    output logic            nv_prog,
    output logic            nv_recall
);

    localparam int MAX_EP  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int MAX_CYC = (MAX_EP > RECALL_CYC) ? MAX_EP : RECALL_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_e       state_q, state_d;
    seq_cmd_t         cmd;
    logic             dirty, ae;
    logic             expired, restart, clr_dirty;
    logic             is_idle, hw_take, op_accept;
    logic [CNT_W-1:0] limit;

    assign is_idle   = (state_q == ST_IDLE);
    assign hw_take   = hw_store_req && dirty;
    assign op_accept = is_idle && !power_fail && !hw_take;

    nv_cmd_decode u_dec (
        .op_valid (op_valid),
        .op_code  (op_code),
        .accept   (op_accept),
        .cmd      (cmd)
    );

    nv_seq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_done   (sram_wr_done),
        .accept_wr (is_idle),
        .clr_dirty (clr_dirty),
        .ae_on     (cmd.ae_on),
        .ae_off    (cmd.ae_off),
        .dirty     (dirty),
        .ae        (ae)
    );

    always_comb begin
        unique case (state_q)
            ST_PROGRAM: limit = CNT_W'(PROG_CYC);
            ST_RECALL:  limit = CNT_W'(RECALL_CYC);
            default:    limit = CNT_W'(ERASE_CYC);
        endcase
    end

    nv_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .expired (expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RECALL;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (power_fail) begin
                    state_d = (ae && dirty) ? ST_ERASE : ST_OFF;
                end else if (hw_take || cmd.store) begin
                    state_d = ST_ERASE;
                end else if (cmd.recall) begin
                    state_d = ST_RECALL;
                end
            end
            ST_ERASE: begin
                if (expired) state_d = ST_PROGRAM;
            end
            ST_PROGRAM: begin
                if (expired) state_d = power_fail ? ST_OFF : ST_IDLE;
            end
            ST_RECALL: begin
                if (expired) state_d = ST_IDLE;
            end
            ST_OFF: begin
                if (!power_fail) state_d = ST_RECALL;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign restart   = (state_d != state_q);
    assign clr_dirty = expired && (state_q == ST_PROGRAM || state_q == ST_RECALL);

    // outputs
    always_comb begin
        nv_erase   = 1'b0;
        nv_prog    = 1'b0;
        nv_recall  = 1'b0;
        io_lock    = 1'b1;
        unique case (state_q)
            ST_IDLE:    io_lock   = 1'b0;
            ST_ERASE:   nv_erase  = 1'b1;
            ST_PROGRAM: nv_prog   = 1'b1;
            ST_RECALL:  nv_recall = 1'b1;
            default:    io_lock   = 1'b1;
        endcase
        status_rdy = nv_erase || nv_prog || nv_recall;
        hsb_n      = !status_rdy;
    end

    AST_ERASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_prog) |-> $past(nv_erase)); // R2

    AST_HW_CLEAN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && !power_fail && hw_store_req && !dirty && !(op_valid && op_code == OPC_STORE))
        |=> !nv_erase); // R5

    AST_SW_STORE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && !power_fail && op_valid && op_code == OPC_STORE) |=> nv_erase); // R6

    AST_CLEAN_AFTER_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_recall && state_d == ST_IDLE) |=> !dirty); // R7

    AST_RECALL_ON_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !power_fail) |=> nv_recall); // R9

    AST_FAIL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && power_fail && !(ae && dirty)) |=> (io_lock && hsb_n)); // R10

endmodule

// File: tb/nv_store_seq_test.sv
module nv_store_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int E = 6;
    localparam int P = 9;
    localparam int R = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic       sram_wr_done = 1'b0;
    logic       hw_store_req = 1'b0;
    logic       power_fail = 1'b0;
    logic       hsb_n, status_rdy, io_lock, nv_erase, nv_prog, nv_recall;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;
    bit  m_dirty = 0;
    bit  m_ae = 1;
    int  busy, er, pr, rc;

    always #(CLK_PERIOD/2) clk = ~clk;

    nv_store_seq #(.ERASE_CYC(E), .PROG_CYC(P), .RECALL_CYC(R)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .sram_wr_done(sram_wr_done), .hw_store_req(hw_store_req),
        .power_fail(power_fail), .hsb_n(hsb_n), .status_rdy(status_rdy),
        .io_lock(io_lock), .nv_erase(nv_erase), .nv_prog(nv_prog),
        .nv_recall(nv_recall)
    );

    function automatic int exp_store_len(bit run);
        return run ? (E + P) : 0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    // Sample at the current falling edge onward until busy ends.
    task automatic measure(input bit noise);
        busy = 0; er = 0; pr = 0; rc = 0;
        while (!hsb_n && busy < 1000) begin
            if (!status_rdy) begin
                fails++; tests++;
                $display("FAIL R3 status_rdy=0 while hsb_n=0 actual=0 expected=1");
            end
            busy++;
            er += int'(nv_erase);
            pr += int'(nv_prog);
            rc += int'(nv_recall);
            if (noise && busy == 2) begin
                hw_store_req = 1'b1; sram_wr_done = 1'b1;
                op_valid = 1'b1; op_code = 8'h60;
            end
            @(negedge clk);
            if (noise && busy == 2) begin
                hw_store_req = 1'b0; sram_wr_done = 1'b0; op_valid = 1'b0;
            end
        end
        if (status_rdy) begin
            fails++; tests++;
            $display("FAIL R3 status_rdy=1 while hsb_n=1 actual=1 expected=0");
        end
    endtask

    task automatic pulse_op(input logic [7:0] code);
        op_valid = 1'b1; op_code = code;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic pulse_wr();
        sram_wr_done = 1'b1;
        @(negedge clk);
        sram_wr_done = 1'b0;
    endtask

    task automatic pulse_hw();
        hw_store_req = 1'b1;
        @(negedge clk);
        hw_store_req = 1'b0;
    endtask

    task automatic power_cycle(input string tag);
        power_fail = 1'b1;
        @(negedge clk);
        measure(0);
        check_eq({tag, " store length on power fail"}, busy, exp_store_len(m_ae && m_dirty));
        repeat (3) @(negedge clk);
        check(io_lock && hsb_n, {tag, " off state locked and not busy"}, int'(io_lock), 1);
        power_fail = 1'b0;
        @(negedge clk);
        measure(0);
        check_eq({tag, " recall after power returns"}, rc, R);
        m_dirty = 0;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd7109));
        @(negedge clk);
        check(!hsb_n && io_lock && nv_recall, "R1 recall during reset", int'(hsb_n), 0);
        @(negedge clk);
        rst_n = 1'b1;
        measure(0);
        check_eq("R1 power-up recall length", rc, R);
        check_eq("R3 busy equals recall length", busy, R);
        check(!io_lock, "R4 unlocked after recall", int'(io_lock), 0);

        // R5: hardware store with clean flag is ignored
        pulse_hw();
        measure(0);
        check_eq("R5 hw store while clean", busy, 0);

        // R6: software store with clean flag still runs
        pulse_op(8'h3C);
        measure(0);
        check_eq("R6 sw store erase cycles", er, E);
        check_eq("R2 program cycles", pr, P);

        // R5: write then hw store runs
        pulse_wr();
        pulse_hw();
        measure(0);
        check_eq("R5 hw store when dirty", busy, E + P);
        pulse_hw();
        measure(0);
        check_eq("R5 dirty cleared by store", busy, 0);

        // R4: traffic during a store is ignored
        pulse_wr();
        pulse_op(8'h3C);
        measure(1);
        check_eq("R4 store not extended by traffic", busy, E + P);
        @(negedge clk);
        check_eq("R4 no recall started by locked opcode", int'(hsb_n), 1);
        pulse_hw();
        measure(0);
        check_eq("R4 locked write did not set dirty", busy, 0);

        // R7: recall clears dirty
        pulse_wr();
        pulse_op(8'h60);
        measure(0);
        check_eq("R7 recall length", rc, R);
        pulse_hw();
        measure(0);
        check_eq("R7 dirty cleared by recall", busy, 0);

        // R10: power fail beats opcode; autostore disabled
        pulse_op(8'h19);
        pulse_wr();
        power_fail = 1'b1; op_valid = 1'b1; op_code = 8'h3C;
        @(negedge clk);
        op_valid = 1'b0;
        measure(0);
        check_eq("R10 power fail wins over store opcode", busy, 0);
        check_eq("R8 autostore disabled skips store", er, 0);
        power_fail = 1'b0;
        @(negedge clk);
        measure(0);
        check_eq("R9 recall after restore", rc, R);

        // R10: hw store (dirty) beats an opcode in the same cycle
        pulse_wr();
        hw_store_req = 1'b1; op_valid = 1'b1; op_code = 8'h59;
        @(negedge clk);
        hw_store_req = 1'b0; op_valid = 1'b0;
        measure(0);
        check_eq("R10 hw store wins", busy, E + P);
        m_ae = 0; m_dirty = 0;
        pulse_wr(); m_dirty = 1;
        power_cycle("R10 ae opcode dropped");

        // R8/R9 enabled autostore
        pulse_op(8'h59); m_ae = 1;
        pulse_wr(); m_dirty = 1;
        power_cycle("R9 autostore");

        // constrained random
        for (int i = 0; i < 80; i++) begin
            int kind;
            kind = int'($urandom % 9);
            case (kind)
                0, 1: begin
                    pulse_wr(); m_dirty = 1;
                    measure(0);
                    check_eq("R5 write causes no busy", busy, 0);
                end
                2: begin
                    pulse_op(8'h3C);
                    measure(0);
                    check_eq("R2 random store erase", er, E);
                    check_eq("R6 random store total", busy, E + P);
                    m_dirty = 0;
                end
                3: begin
                    pulse_op(8'h60);
                    measure(0);
                    check_eq("R7 random recall", rc, R);
                    m_dirty = 0;
                end
                4: begin
                    pulse_op(8'h59); m_ae = 1;
                    measure(0);
                    check_eq("R8 enable opcode no busy", busy, 0);
                end
                5: begin
                    pulse_op(8'h19); m_ae = 0;
                    measure(0);
                    check_eq("R8 disable opcode no busy", busy, 0);
                end
                6: begin
                    pulse_hw();
                    measure(0);
                    check_eq("R5 random hw store", busy, exp_store_len(m_dirty));
                    m_dirty = 0;
                end
                7: power_cycle("R9 random power cycle");
                default: begin
                    pulse_op(8'hA5);
                    measure(0);
                    check_eq("R8 unknown opcode ignored", busy, 0);
                end
            endcase
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule